// File: doc/BRIEF.md
# Stack Processor Command Execution Unit

This unit carries out one command of a 16-bit stack processor at a time. It takes a 5-bit command code and two operands that have already been fetched. It holds the stack pointer, the frame base pointer and the flag word, and it takes the current instruction pointer as an input. Every accepted command produces one result word. Commands that touch memory issue a single read or write request on a simple memory port.

A command is offered with `in_valid` and is taken on a clock edge where `in_ready` is high. Commands that only compute, or that only write memory, deliver their result in the next cycle. Commands that read memory first spend one cycle with the read request on the port. The memory answers combinationally on `mem_rdata` during that cycle: the byte at `mem_addr` in bits 7:0 and the byte at `mem_addr + 1` in bits 15:8. The result is delivered one cycle later, and no new command is taken while the read is pending.

Top module: `stk_exec_unit`

## Requirements
- R1: While reset is asserted (synchronous, active-low), the outputs read `in_ready`=1, `res_valid`=0, `mem_rd`=0 and `mem_wr`=0, and the stack pointer, frame pointer and flag word are all 0.
- R2: A command accepted at an edge that does not read memory raises `res_valid` for exactly the following cycle. A memory-reading command (codes 2, 6, 7) raises `mem_rd` for the following cycle with `in_ready` low, then raises `res_valid` in the cycle after that. `mem_rd` and `mem_wr` are never high together.
- R3: The unary and bitwise commands return these values. Code 0 returns op0. Code 21 returns op0 AND op1, 22 returns op0 OR op1, 23 returns op0 XOR op1 and 24 returns NOT op0. Code 25 returns op0[7:0] with bit 7 copied into bits 15:8. Code 28 swaps the two bytes of op0. Codes 26 and 27 rotate op0 left and right by one bit. Code 29 shifts op0 right by one and keeps the sign bit. Codes 30 and 31 shift op0 left and right by one bit and fill with zero.
- R4: Code 16 returns op0+op1 and code 17 returns op0-op1, both modulo 2^16. The unsigned carry of the add, or the borrow of the subtract, is written into flag bit 2. No other command except code 11 changes flag bit 2.
- R5: Code 18 returns the low 16 bits of op0*op1. Codes 19 and 20 return the unsigned quotient and remainder. A zero divisor gives 0xFFFF for code 19 and op0 for code 20.
- R6: Code 2 reads the word at BP + 2*op0 and returns it. Code 3 writes op1 as a word to BP + 2*op0 and returns op1. Address arithmetic wraps at 16 bits.
- R7: Code 5 writes op1 as a word to address op0 with `mem_byte`=0 and returns op1. Code 4 writes op1[7:0] to address op0 with `mem_byte`=1 and returns op1[7:0] zero-extended.
- R8: Code 7 returns `mem_rdata` from address op0. Code 6 returns `mem_rdata[7:0]` zero-extended, read with `mem_byte`=1.
- R9: Code 1 returns IP + 2*op0.
- R10: Code 15 loads op0 into SP and code 13 loads op0 into BP, and both return op0. Codes 14 and 12 return the current SP and BP.
- R11: Code 11 replaces the flag word with (flags AND op1) OR (op0 AND NOT op1), with bits 15:8 forced to 0, and returns the new word. Code 10 returns the flag word. Flag bits 15:8 always read 0.
- R12: Codes 8 and 9 return 0 with `trap` high in the result cycle. They leave SP, BP and the flags unchanged and issue no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Command offered |
| in_ready | output | 1 | Unit can take a command this cycle |
| cmd | input | 5 | Command code |
| op0 | input | 16 | First operand |
| op1 | input | 16 | Second operand |
| ip_in | input | 16 | Current instruction pointer |
| res_valid | output | 1 | Result word present this cycle |
| res_data | output | 16 | Result word |
| trap | output | 1 | Result belongs to an undefined command |
| sp_o | output | 16 | Stack pointer |
| bp_o | output | 16 | Frame base pointer |
| fr_o | output | 16 | Flag word (zero, negative, carry, carry-enable, four interrupt enables, upper byte 0) |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_byte | output | 1 | Request is a single byte |
| mem_addr | output | 16 | Byte address of the request |
| mem_wdata | output | 16 | Write data (byte writes use bits 7:0) |
| mem_rdata | input | 16 | Read data, valid combinationally while `mem_rd` is high |

## Verification
A compute or write command has its result and any write request due one cycle after the edge that accepts it. A memory-reading command has its read request due one cycle after acceptance and its result due two cycles after. The driver records the cycle count at acceptance and stores the cycle each result is due in the expected item it queues. The monitor pops an item on every `res_valid` and checks the data, the trap bit and that the arrival cycle matches the due cycle. Read and write requests are matched against their own queues, so any request that was not expected counts as a failure.

// File: rtl/stk_pkg.sv
// Shared types for the stack command execution unit.
// Assumes a 5-bit command field whose codes are fixed by the instruction format.
package stk_pkg;

    typedef enum logic [4:0] {
        C_COPY  = 5'd0,  C_IPGET = 5'd1,  C_GET   = 5'd2,  C_SET   = 5'd3,
        C_ST8   = 5'd4,  C_ST16  = 5'd5,  C_LD8   = 5'd6,  C_LD16  = 5'd7,
        C_UND0  = 5'd8,  C_UND1  = 5'd9,  C_FRGET = 5'd10, C_FRSET = 5'd11,
        C_BPGET = 5'd12, C_BPSET = 5'd13, C_SPGET = 5'd14, C_SPSET = 5'd15,
        C_ADD   = 5'd16, C_SUB   = 5'd17, C_MUL   = 5'd18, C_DIV   = 5'd19,
        C_MOD   = 5'd20, C_AND   = 5'd21, C_OR    = 5'd22, C_XOR   = 5'd23,
        C_NOT   = 5'd24, C_SEXT  = 5'd25, C_ROL   = 5'd26, C_ROR   = 5'd27,
        C_BSWAP = 5'd28, C_ASR   = 5'd29, C_LSL   = 5'd30, C_LSR   = 5'd31
    } stk_cmd_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WAIT = 1'b1
    } stk_phase_e;

    // Flag word bit positions; bits at and above FLAG_USED are reserved zero.
    localparam int FLAG_Z    = 0;
    localparam int FLAG_N    = 1;
    localparam int FLAG_C    = 2;
    localparam int FLAG_CE   = 3;
    localparam int FLAG_USED = 8;

endpackage

// File: rtl/stk_alu.sv
// Combinational result generator for every command that does not return memory data.
// Assumes W is even and larger than the used flag bits; outputs are 0 for memory-read and undefined codes.
module stk_alu
    import stk_pkg::*;
#(
    parameter int W = 16
) (
    input  stk_cmd_e       cmd,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [W-1:0]   ip,
    input  logic [W-1:0]   sp,
    input  logic [W-1:0]   bp,
    input  logic [W-1:0]   fr,
    output logic [W-1:0]   res,
    output logic [W-1:0]   fr_next,
    output logic           carry_we,
    output logic           carry_val
);
    localparam int HB = W / 2;
    localparam logic [W-1:0] FLAG_MASK = {{(W-FLAG_USED){1'b0}}, {FLAG_USED{1'b1}}};

    logic [W:0] sum_x;
    logic [W:0] diff_x;

    // Wide add and subtract so the carry and borrow are the top bit.
    always_comb begin
        sum_x  = {1'b0, a} + {1'b0, b};
        diff_x = {1'b0, a} - {1'b0, b};
        fr_next = ((fr & b) | (a & ~b)) & FLAG_MASK;
    end

    // Per-command result selection.
    always_comb begin
        res       = '0;
        carry_we  = 1'b0;
        carry_val = 1'b0;
        case (cmd)
            C_COPY:  res = a;
            C_IPGET: res = ip + {a[W-2:0], 1'b0};
            C_SET:   res = b;
            C_ST16:  res = b;
            C_ST8:   res = {{(W-HB){1'b0}}, b[HB-1:0]};
            C_FRGET: res = fr;
            C_FRSET: res = fr_next;
            C_BPGET: res = bp;
            C_BPSET: res = a;
            C_SPGET: res = sp;
            C_SPSET: res = a;
            C_ADD: begin
                res       = sum_x[W-1:0];
                carry_we  = 1'b1;
                carry_val = sum_x[W];
            end
            C_SUB: begin
                res       = diff_x[W-1:0];
                carry_we  = 1'b1;
                carry_val = diff_x[W];
            end
            C_MUL:   res = a * b;
            C_DIV:   res = (b == '0) ? {W{1'b1}} : a / b;
            C_MOD:   res = (b == '0) ? a : a % b;
            C_AND:   res = a & b;
            C_OR:    res = a | b;
            C_XOR:   res = a ^ b;
            C_NOT:   res = ~a;
            C_SEXT:  res = {{(W-HB){a[HB-1]}}, a[HB-1:0]};
            C_ROL:   res = {a[W-2:0], a[W-1]};
            C_ROR:   res = {a[0], a[W-1:1]};
            C_BSWAP: res = {a[HB-1:0], a[W-1:HB]};
            C_ASR:   res = {a[W-1], a[W-1:1]};
            C_LSL:   res = {a[W-2:0], 1'b0};
            C_LSR:   res = {1'b0, a[W-1:1]};
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/stk_agu.sv
// Address and request decoder for the memory-touching commands.
// Assumes frame-relative accesses address whole words, so the index is scaled by two.
module stk_agu
    import stk_pkg::*;
#(
    parameter int W = 16
) (
    input  stk_cmd_e       cmd,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [W-1:0]   bp,
    output logic           rd_req,
    output logic           wr_req,
    output logic           byte_sel,
    output logic [W-1:0]   addr,
    output logic [W-1:0]   wdata
);
    logic frame_rel;

    // Classify the command and form the byte address.
    always_comb begin
        frame_rel = (cmd == C_GET) || (cmd == C_SET);
        rd_req    = (cmd == C_GET) || (cmd == C_LD8) || (cmd == C_LD16);
        wr_req    = (cmd == C_SET) || (cmd == C_ST8) || (cmd == C_ST16);
        byte_sel  = (cmd == C_LD8) || (cmd == C_ST8);
        addr      = frame_rel ? bp + {a[W-2:0], 1'b0} : a;
        wdata     = b;
    end

endmodule

// File: rtl/stk_state_regs.sv
// Holds the stack pointer, the frame pointer and the flag word.
// Assumes a full flag write takes priority over a carry-only update in the same cycle.
module stk_state_regs
    import stk_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sp_we,
    input  logic           bp_we,
    input  logic           fr_we,
    input  logic           carry_we,
    input  logic [W-1:0]   din,
    input  logic [W-1:0]   fr_din,
    input  logic           carry_val,
    output logic [W-1:0]   sp,
    output logic [W-1:0]   bp,
    output logic [W-1:0]   fr
);
    // Pointer registers load the first operand when written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= '0;
            bp <= '0;
        end else begin
            if (sp_we) sp <= din;
            if (bp_we) bp <= din;
        end
    end

    // Flag word: a masked full write, or a carry-bit-only update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fr <= '0;
        end else if (fr_we) begin
            fr <= fr_din;
        end else if (carry_we) begin
            fr[FLAG_C] <= carry_val;
        end
    end

endmodule

// File: rtl/stk_exec_unit.sv
// Top of the command execution unit: takes one command, issues at most one memory request, returns one result.
// Assumes memory read data is valid combinationally while mem_rd is high.
module stk_exec_unit
    import stk_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [4:0]     cmd,
    input  logic [W-1:0]   op0,
    input  logic [W-1:0]   op1,
    input  logic [W-1:0]   ip_in,
    output logic           res_valid,
    output logic [W-1:0]   res_data,
    output logic           trap,
    output logic [W-1:0]   sp_o,
    output logic [W-1:0]   bp_o,
    output logic [W-1:0]   fr_o,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic           mem_byte,
    output logic [W-1:0]   mem_addr,
    output logic [W-1:0]   mem_wdata,
    input  logic [W-1:0]   mem_rdata
);
    localparam int HB = W / 2;

    stk_cmd_e   cmd_e;
    stk_phase_e phase;
    logic       accept;
    logic       is_undef;

    logic [W-1:0] alu_res;
    logic [W-1:0] fr_next;
    logic         alu_carry_we;
    logic         alu_carry_val;

    logic         agu_rd;
    logic         agu_wr;
    logic         agu_byte;
    logic [W-1:0] agu_addr;
    logic [W-1:0] agu_wdata;

    logic         res_valid_q;
    logic [W-1:0] res_q;
    logic         trap_q;
    logic         mem_rd_q;
    logic         mem_wr_q;
    logic         mem_byte_q;
    logic [W-1:0] addr_q;
    logic [W-1:0] wdata_q;

    // Command decode and handshake.
    always_comb begin
        cmd_e    = stk_cmd_e'(cmd);
        in_ready = (phase == PH_IDLE);
        accept   = in_valid && in_ready;
        is_undef = (cmd_e == C_UND0) || (cmd_e == C_UND1);
    end

    stk_alu #(.W(W)) u_alu (
        .cmd       (cmd_e),
        .a         (op0),
        .b         (op1),
        .ip        (ip_in),
        .sp        (sp_o),
        .bp        (bp_o),
        .fr        (fr_o),
        .res       (alu_res),
        .fr_next   (fr_next),
        .carry_we  (alu_carry_we),
        .carry_val (alu_carry_val)
    );

    stk_agu #(.W(W)) u_agu (
        .cmd      (cmd_e),
        .a        (op0),
        .b        (op1),
        .bp       (bp_o),
        .rd_req   (agu_rd),
        .wr_req   (agu_wr),
        .byte_sel (agu_byte),
        .addr     (agu_addr),
        .wdata    (agu_wdata)
    );

    stk_state_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sp_we     (accept && (cmd_e == C_SPSET)),
        .bp_we     (accept && (cmd_e == C_BPSET)),
        .fr_we     (accept && (cmd_e == C_FRSET)),
        .carry_we  (accept && alu_carry_we),
        .din       (op0),
        .fr_din    (fr_next),
        .carry_val (alu_carry_val),
        .sp        (sp_o),
        .bp        (bp_o),
        .fr        (fr_o)
    );

    // Two-phase sequencer: issue the request or the result, then finish a pending read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_IDLE;
            res_valid_q <= 1'b0;
            res_q       <= '0;
            trap_q      <= 1'b0;
            mem_rd_q    <= 1'b0;
            mem_wr_q    <= 1'b0;
            mem_byte_q  <= 1'b0;
            addr_q      <= '0;
            wdata_q     <= '0;
        end else begin
            res_valid_q <= 1'b0;
            trap_q      <= 1'b0;
            mem_rd_q    <= 1'b0;
            mem_wr_q    <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        mem_byte_q <= agu_byte;
                        addr_q     <= agu_addr;
                        wdata_q    <= agu_wdata;
                        if (agu_rd) begin
                            mem_rd_q <= 1'b1;
                            phase    <= PH_WAIT;
                        end else begin
                            res_valid_q <= 1'b1;
                            res_q       <= alu_res;
                            trap_q      <= is_undef;
                            mem_wr_q    <= agu_wr;
                        end
                    end
                end
                PH_WAIT: begin
                    res_valid_q <= 1'b1;
                    res_q       <= mem_byte_q ? {{(W-HB){1'b0}}, mem_rdata[HB-1:0]} : mem_rdata;
                    phase       <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Output mapping.
    always_comb begin
        res_valid = res_valid_q;
        res_data  = res_q;
        trap      = trap_q;
        mem_rd    = mem_rd_q;
        mem_wr    = mem_wr_q;
        mem_byte  = mem_byte_q;
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
    end

endmodule

// File: rtl/stk_exec_chk.sv
// Protocol and state checks for stk_exec_unit, attached by bind.
// Assumes it sees only the ports of the unit.
module stk_exec_chk #(
    parameter int W = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           in_ready,
    input logic [4:0]     cmd,
    input logic [W-1:0]   op0,
    input logic           res_valid,
    input logic [W-1:0]   res_data,
    input logic           trap,
    input logic [W-1:0]   sp_o,
    input logic [W-1:0]   bp_o,
    input logic [W-1:0]   fr_o,
    input logic           mem_rd,
    input logic           mem_wr
);
    logic acc;
    logic rd_cmd;
    logic und_cmd;

    // Port-level view of acceptance and command class.
    always_comb begin
        acc     = in_valid && in_ready;
        rd_cmd  = (cmd == 5'd2) || (cmd == 5'd6) || (cmd == 5'd7);
        und_cmd = (cmd == 5'd8) || (cmd == 5'd9);
    end

    assert_read_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && rd_cmd) |=> (mem_rd && !in_ready && !res_valid));

    assert_read_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (res_valid && in_ready));

    assert_fast_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !rd_cmd) |=> res_valid);

    assert_req_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_flag_reserved_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fr_o[W-1:8] == '0);

    assert_spset_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd == 5'd15) |=> (sp_o == $past(op0)));

    assert_trap_result_R12: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (res_valid && res_data == '0 && !mem_wr && !mem_rd));

    assert_trap_keeps_state_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && und_cmd) |=> ($stable(sp_o) && $stable(bp_o) && $stable(fr_o)));

endmodule

bind stk_exec_unit stk_exec_chk #(.W(W)) u_stk_exec_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .cmd       (cmd),
    .op0       (op0),
    .res_valid (res_valid),
    .res_data  (res_data),
    .trap      (trap),
    .sp_o      (sp_o),
    .bp_o      (bp_o),
    .fr_o      (fr_o),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr)
);

// File: tb/tb_stk_exec_unit.sv
// Scoreboard bench: the driver queues expected results and memory requests, the monitor matches them.
module tb_stk_exec_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [4:0]  cmd = '0;
    logic [15:0] op0 = '0;
    logic [15:0] op1 = '0;
    logic [15:0] ip_in = '0;
    logic        res_valid;
    logic [15:0] res_data;
    logic        trap;
    logic [15:0] sp_o;
    logic [15:0] bp_o;
    logic [15:0] fr_o;
    logic        mem_rd;
    logic        mem_wr;
    logic        mem_byte;
    logic [15:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;

    always #2 clk = ~clk;

    stk_exec_unit #(.W(16)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .cmd(cmd), .op0(op0), .op1(op1), .ip_in(ip_in),
        .res_valid(res_valid), .res_data(res_data), .trap(trap),
        .sp_o(sp_o), .bp_o(bp_o), .fr_o(fr_o),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_byte(mem_byte),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Byte memory model: preset during reset, written by the unit's requests.
    logic [7:0] bmem [256];
    logic [7:0] a_lo;
    logic [7:0] a_hi;
    assign a_lo = mem_addr[7:0];
    assign a_hi = mem_addr[7:0] + 8'd1;
    assign mem_rdata = {bmem[a_hi], bmem[a_lo]};

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) bmem[i] <= 8'(i) ^ 8'hA5;
        end else if (mem_wr) begin
            bmem[a_lo] <= mem_wdata[7:0];
            if (!mem_byte) bmem[a_hi] <= mem_wdata[15:8];
        end
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [15:0] data;
        logic        trp;
        int          due;
        string       tag;
    } res_item_t;

    typedef struct {
        logic [15:0] addr;
        logic [15:0] data;
        logic        bsel;
        string       tag;
    } mem_item_t;

    res_item_t res_q[$];
    mem_item_t wr_q[$];
    mem_item_t rd_q[$];

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_wr(input logic [15:0] addr, input logic [15:0] data, input logic bsel, input string tag);
        mem_item_t it;
        it.addr = addr; it.data = data; it.bsel = bsel; it.tag = tag;
        wr_q.push_back(it);
    endtask

    task automatic expect_rd(input logic [15:0] addr, input logic bsel, input string tag);
        mem_item_t it;
        it.addr = addr; it.data = '0; it.bsel = bsel; it.tag = tag;
        rd_q.push_back(it);
    endtask

    // Driver: offer a command, wait for acceptance, queue the expected result with its due cycle.
    task automatic issue(input logic [4:0] c, input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] exp, input logic trp, input string tag);
        res_item_t it;
        bit rd;
        rd = (c == 5'd2) || (c == 5'd6) || (c == 5'd7);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        cmd = c; op0 = a; op1 = b; in_valid = 1'b1;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        it.data = exp; it.trp = trp; it.due = cyc + (rd ? 1 : 0); it.tag = tag;
        res_q.push_back(it);
    endtask

    // Monitor: match results and memory requests against the queues.
    always @(negedge clk) begin
        if (rst_n) begin
            if (res_valid) begin
                if (res_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected result", res_data, 16'h0);
                end else begin
                    res_item_t it;
                    it = res_q.pop_front();
                    chk(res_data == it.data, {it.tag, " data"}, res_data, it.data);
                    chk(trap == it.trp, {it.tag, " trap"}, 16'(trap), 16'(it.trp));
                    chk(cyc == it.due, {it.tag, " R2 cycle"}, 16'(cyc), 16'(it.due));
                end
            end
            if (mem_wr) begin
                if (wr_q.size() == 0) begin
                    chk(1'b0, "R12 unexpected write", mem_addr, 16'h0);
                end else begin
                    mem_item_t w;
                    w = wr_q.pop_front();
                    chk(mem_addr == w.addr, {w.tag, " write addr"}, mem_addr, w.addr);
                    chk(mem_byte == w.bsel, {w.tag, " write size"}, 16'(mem_byte), 16'(w.bsel));
                    if (w.bsel)
                        chk(mem_wdata[7:0] == w.data[7:0], {w.tag, " write byte"}, mem_wdata, w.data);
                    else
                        chk(mem_wdata == w.data, {w.tag, " write word"}, mem_wdata, w.data);
                end
            end
            if (mem_rd) begin
                if (rd_q.size() == 0) begin
                    chk(1'b0, "R12 unexpected read", mem_addr, 16'h0);
                end else begin
                    mem_item_t r;
                    r = rd_q.pop_front();
                    chk(mem_addr == r.addr, {r.tag, " read addr"}, mem_addr, r.addr);
                    chk(mem_byte == r.bsel, {r.tag, " read size"}, 16'(mem_byte), 16'(r.bsel));
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        ip_in = 16'h0200;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: state while reset is held
        chk(in_ready == 1'b1, "R1 in_ready", 16'(in_ready), 16'h1);
        chk(res_valid == 1'b0, "R1 res_valid", 16'(res_valid), 16'h0);
        chk(!mem_rd && !mem_wr, "R1 mem req", {14'h0, mem_rd, mem_wr}, 16'h0);
        chk(sp_o == 16'h0, "R1 sp", sp_o, 16'h0);
        chk(bp_o == 16'h0, "R1 bp", bp_o, 16'h0);
        chk(fr_o == 16'h0, "R1 flags", fr_o, 16'h0);
        rst_n = 1'b1;

        // R3: bitwise, shift, rotate, swap and sign extension
        issue(5'd0,  16'h1234, 16'h0,    16'h1234, 1'b0, "R3 copy");
        issue(5'd24, 16'h00FF, 16'h0,    16'hFF00, 1'b0, "R3 not");
        issue(5'd28, 16'h12AB, 16'h0,    16'hAB12, 1'b0, "R3 bswap");
        issue(5'd25, 16'h0080, 16'h0,    16'hFF80, 1'b0, "R3 signext neg");
        issue(5'd25, 16'h1234, 16'h0,    16'h0034, 1'b0, "R3 signext pos");
        issue(5'd21, 16'hF0F0, 16'h3C3C, 16'h3030, 1'b0, "R3 and");
        issue(5'd22, 16'hF0F0, 16'h3C3C, 16'hFCFC, 1'b0, "R3 or");
        issue(5'd23, 16'hF0F0, 16'h3C3C, 16'hCCCC, 1'b0, "R3 xor");
        issue(5'd30, 16'h8001, 16'h0,    16'h0002, 1'b0, "R3 lsl");
        issue(5'd31, 16'h8001, 16'h0,    16'h4000, 1'b0, "R3 lsr");
        issue(5'd26, 16'h8001, 16'h0,    16'h0003, 1'b0, "R3 rol");
        issue(5'd27, 16'h8001, 16'h0,    16'hC000, 1'b0, "R3 ror");
        issue(5'd29, 16'h8002, 16'h0,    16'hC001, 1'b0, "R3 asr");

        // R4: carry and borrow into flag bit 2, other commands keep it
        issue(5'd16, 16'hFFFF, 16'h0002, 16'h0001, 1'b0, "R4 add carry");
        issue(5'd10, 16'h0,    16'h0,    16'h0004, 1'b0, "R4 carry set");
        issue(5'd16, 16'h0001, 16'h0002, 16'h0003, 1'b0, "R4 add");
        issue(5'd10, 16'h0,    16'h0,    16'h0000, 1'b0, "R4 carry clear");
        issue(5'd17, 16'h0001, 16'h0002, 16'hFFFF, 1'b0, "R4 sub borrow");
        issue(5'd18, 16'h0100, 16'h0101, 16'h0100, 1'b0, "R5 mul low");
        issue(5'd10, 16'h0,    16'h0,    16'h0004, 1'b0, "R4 carry kept");
        issue(5'd17, 16'h0005, 16'h0003, 16'h0002, 1'b0, "R4 sub");

        // R5: unsigned divide and remainder, zero divisor
        issue(5'd19, 16'd100,  16'd7,    16'h000E, 1'b0, "R5 div");
        issue(5'd20, 16'd100,  16'd7,    16'h0002, 1'b0, "R5 mod");
        issue(5'd19, 16'h8000, 16'h0003, 16'h2AAA, 1'b0, "R5 div unsigned");
        issue(5'd19, 16'h1234, 16'h0,    16'hFFFF, 1'b0, "R5 div zero");
        issue(5'd20, 16'h0042, 16'h0,    16'h0042, 1'b0, "R5 mod zero");

        // R11: masked flag write, reserved byte stays 0
        issue(5'd11, 16'hFFFF, 16'h0000, 16'h00FF, 1'b0, "R11 frset all");
        issue(5'd10, 16'h0,    16'h0,    16'h00FF, 1'b0, "R11 frget");
        issue(5'd11, 16'h0000, 16'h00F0, 16'h00F0, 1'b0, "R11 frset mask");
        @(negedge clk);
        chk(fr_o == 16'h00F0, "R11 flag port", fr_o, 16'h00F0);
        issue(5'd11, 16'h0000, 16'h0000, 16'h0000, 1'b0, "R11 frset clear");

        // R10: pointer set and get
        issue(5'd15, 16'h0040, 16'h0,    16'h0040, 1'b0, "R10 spset");
        issue(5'd14, 16'h0,    16'h0,    16'h0040, 1'b0, "R10 spget");
        issue(5'd13, 16'h0010, 16'h0,    16'h0010, 1'b0, "R10 bpset");
        issue(5'd12, 16'h0,    16'h0,    16'h0010, 1'b0, "R10 bpget");

        // R9: instruction pointer relative value
        issue(5'd1,  16'h0003, 16'h0,    16'h0206, 1'b0, "R9 ipget");

        // R8: loads
        expect_rd(16'h0020, 1'b0, "R8 load16");
        issue(5'd7,  16'h0020, 16'h0,    16'h8485, 1'b0, "R8 load16");
        expect_rd(16'h0021, 1'b1, "R8 load8");
        issue(5'd6,  16'h0021, 16'h0,    16'h0084, 1'b0, "R8 load8");

        // R6: frame-relative read
        expect_rd(16'h0016, 1'b0, "R6 get");
        issue(5'd2,  16'h0003, 16'h0,    16'hB2B3, 1'b0, "R6 get");

        // R7: stores and read-back
        expect_wr(16'h0030, 16'hBEEF, 1'b0, "R7 store16");
        issue(5'd5,  16'h0030, 16'hBEEF, 16'hBEEF, 1'b0, "R7 store16");
        expect_rd(16'h0030, 1'b0, "R7 readback16");
        issue(5'd7,  16'h0030, 16'h0,    16'hBEEF, 1'b0, "R7 readback16");
        expect_wr(16'h0041, 16'h0077, 1'b1, "R7 store8");
        issue(5'd4,  16'h0041, 16'h1277, 16'h0077, 1'b0, "R7 store8");
        expect_rd(16'h0041, 1'b0, "R7 readback8");
        issue(5'd7,  16'h0041, 16'h0,    16'hE777, 1'b0, "R7 readback8");

        // R6: frame-relative write then read
        expect_wr(16'h0020, 16'h5A5A, 1'b0, "R6 set");
        issue(5'd3,  16'h0008, 16'h5A5A, 16'h5A5A, 1'b0, "R6 set");
        expect_rd(16'h0020, 1'b0, "R6 get after set");
        issue(5'd2,  16'h0008, 16'h0,    16'h5A5A, 1'b0, "R6 get after set");

        // R12: undefined codes trap and change nothing
        issue(5'd8,  16'hFFFF, 16'hFFFF, 16'h0000, 1'b1, "R12 undef 8");
        issue(5'd9,  16'h1111, 16'h2222, 16'h0000, 1'b1, "R12 undef 9");
        issue(5'd14, 16'h0,    16'h0,    16'h0040, 1'b0, "R12 sp kept");
        issue(5'd12, 16'h0,    16'h0,    16'h0010, 1'b0, "R12 bp kept");
        issue(5'd10, 16'h0,    16'h0,    16'h0000, 1'b0, "R12 flags kept");

        repeat (4) @(negedge clk);
        chk(res_q.size() == 0, "R2 results drained", 16'(res_q.size()), 16'h0);
        chk(wr_q.size() == 0 && rd_q.size() == 0, "R2 requests drained",
            16'(wr_q.size() + rd_q.size()), 16'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule